// File: doc/BRIEF.md
# Ethernet MAC Control/Status Register and Interrupt Unit

This block is the software-visible register file of a fast Ethernet MAC. A processor reaches it over a simple 32-bit bus whose addresses are decoded within a 1 KB window. The block keeps a set of sticky event flags and a mask for them, and it drives thirteen separate interrupt lines from the flags that are masked in. It also holds the MAC enable and soft-reset control, the receive and transmit configuration, the 48-bit station address, the FIFO settings, the start addresses of the two descriptor rings and the largest receive buffer size. These values go straight to the transmit and receive engines. The engines report back through one-cycle event pulses and a receive-halt pulse.

The bus carries no back-pressure. A request is taken in every cycle that `req_valid` is high. A write acts at that clock edge. A read returns its data one cycle later, marked by `rsp_valid`, and the result cannot be stalled. The engine-facing pins are plain level or pulse signals. The management-interface engine, the statistics counters and address hashing are not part of this unit. Their locations read back as fixed values.

Top module: `fec_csr_top`

## Requirements
- R1: After `rst_n` is released, all `irq_o` lines are 0 and the event and mask registers read 0. The receive configuration reads 0x05EE0001, the receive FIFO start reads 0x500 and the upper address register reads 0x00008808.
- R2: A read accepted at a clock edge drives `rsp_valid` high, with `rsp_rdata`, for exactly the following cycle. `rsp_valid` is low in every other cycle.
- R3: A pulse on `evt_set_i[k]` sets event register bit 19+k (offset 0x004), and the bit stays set until software clears it. The bit positions are: UN 19, RL 20, LC 21, EB 22, MII 23, RXB 24, RXF 25, TXB 26, TXF 27, GRA 28, BABT 29, BABR 30, HB 31.
- R4: A write to the event register clears each bit written as 1 and leaves the others unchanged. When a clear and an event pulse hit the same bit in the same cycle, the bit stays set.
- R5: A write to the mask register (offset 0x008) replaces all 32 bits. `irq_o[i]` equals (event AND mask) for the i-th source of this list: TXF, TXB, UN, RL, RXF, RXB, MII, LC, HB, GRA, EB, BABT, BABR. The line follows one clock after a change in the event or mask register.
- R6: A write to the transmit configuration register (offset 0x0C4) with bit 0 set sets the GRA event (bit 28).
- R7: In the control register (offset 0x024), bit 1 is the enable and drives `mac_en_o`. A write with bit 0 set is a soft reset. It clears control, event, mask, MII speed, transmit configuration and transmit watermark, and it restores receive configuration to 0x05EE0001 and receive FIFO start to 0x500. The ring starts, the maximum buffer size and the station address keep their values.
- R8: A write to offset 0x010 while enabled sets receive-active. Receive-active reads back as bit 24 at 0x010 and drives `rx_active_o`. The same write while disabled is ignored. A control write with bit 1 clear turns receive-active off, and so does a `rx_halt_i` pulse, which wins over a same-cycle activate.
- R9: A write to offset 0x014 while enabled gives a one-cycle `tx_kick_o` pulse in the cycle after the write. The same write while disabled gives no pulse. The location reads 0.
- R10: Some locations keep only part of what is written. MII speed (0x044) keeps value & 0xFE, receive configuration (0x084) keeps value & 0x07FF003F, transmit watermark (0x144) keeps value & 0x3, and maximum buffer (0x188) keeps value & 0x7F0. Receive FIFO start (0x150) stores (value & 0x3FC) | 0x400. The receive ring (0x180) and transmit ring (0x184) clear bits 1:0 and drive `rx_ring_o` and `tx_ring_o`.
- R11: The lower address register (0x0E4) holds station bytes 0..3 from bit 31 down. The upper register (0x0E8) holds bytes 4..5 in bits 31:16 and reads 0x8808 in bits 15:0. `station_addr_o` is byte 0 in bits 47:40 through byte 5 in bits 7:0.
- R12: Offset 0x0EC reads 0x00010000. Offset 0x14C reads 0x600 and ignores writes. Offsets 0x064 and 0x118 to 0x124 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| evt_set_i | input | 13 | Event pulses; bit k sets event bit 19+k |
| rx_halt_i | input | 1 | Receive engine ran out of buffers |
| irq_o | output | 13 | Interrupt lines in fixed source order |
| mac_en_o | output | 1 | MAC enable |
| rx_active_o | output | 1 | Receive descriptors armed |
| tx_kick_o | output | 1 | Transmit start pulse |
| rx_cfg_o | output | 32 | Receive configuration |
| tx_cfg_o | output | 32 | Transmit configuration |
| station_addr_o | output | 48 | Station MAC address |
| rx_ring_o | output | 32 | Receive ring start |
| tx_ring_o | output | 32 | Transmit ring start |
| rx_buf_max_o | output | 32 | Maximum receive buffer size |

## Verification
The hardest case to reach is a software clear of an event bit in the same cycle that an engine pulses that bit. Ordinary bus sequences never line the two up. The stimulus therefore drives the write request and `evt_set_i` in one chosen cycle, then reads back to show that the flag survived. Every one of the thirteen interrupt lines is also driven alone with the mask fully open, which exposes any crossed wire in the source order. A mask that admits a single source is then applied while all events are pending.

// File: rtl/fec_csr_pkg.sv
package fec_csr_pkg;
  localparam int CSR_AW  = 10;
  localparam int CSR_DW  = 32;
  localparam int N_EVT   = 13;
  localparam int EVT_LSB = CSR_DW - N_EVT;

  // event indices relative to EVT_LSB
  localparam int E_UN = 0, E_RL = 1, E_LC = 2, E_EB = 3, E_MII = 4, E_RXB = 5;
  localparam int E_RXF = 6, E_TXB = 7, E_TXF = 8, E_GRA = 9, E_BABT = 10;
  localparam int E_BABR = 11, E_HB = 12;

  localparam logic [CSR_AW-1:0] OFF_EVT    = 10'h004;
  localparam logic [CSR_AW-1:0] OFF_MSK    = 10'h008;
  localparam logic [CSR_AW-1:0] OFF_RXACT  = 10'h010;
  localparam logic [CSR_AW-1:0] OFF_TXACT  = 10'h014;
  localparam logic [CSR_AW-1:0] OFF_CTL    = 10'h024;
  localparam logic [CSR_AW-1:0] OFF_MGMT   = 10'h040;
  localparam logic [CSR_AW-1:0] OFF_MSPD   = 10'h044;
  localparam logic [CSR_AW-1:0] OFF_MIB    = 10'h064;
  localparam logic [CSR_AW-1:0] OFF_RXCFG  = 10'h084;
  localparam logic [CSR_AW-1:0] OFF_TXCFG  = 10'h0C4;
  localparam logic [CSR_AW-1:0] OFF_STA_LO = 10'h0E4;
  localparam logic [CSR_AW-1:0] OFF_STA_HI = 10'h0E8;
  localparam logic [CSR_AW-1:0] OFF_PAUSE  = 10'h0EC;
  localparam logic [CSR_AW-1:0] OFF_HASH0  = 10'h118;
  localparam logic [CSR_AW-1:0] OFF_HASH1  = 10'h11C;
  localparam logic [CSR_AW-1:0] OFF_HASH2  = 10'h120;
  localparam logic [CSR_AW-1:0] OFF_HASH3  = 10'h124;
  localparam logic [CSR_AW-1:0] OFF_TXWM   = 10'h144;
  localparam logic [CSR_AW-1:0] OFF_FBOUND = 10'h14C;
  localparam logic [CSR_AW-1:0] OFF_RXFIFO = 10'h150;
  localparam logic [CSR_AW-1:0] OFF_RXRING = 10'h180;
  localparam logic [CSR_AW-1:0] OFF_TXRING = 10'h184;
  localparam logic [CSR_AW-1:0] OFF_BUFMAX = 10'h188;

  localparam logic [CSR_DW-1:0] RXCFG_RST  = 32'h05EE_0001;
  localparam logic [CSR_DW-1:0] RXFIFO_RST = 32'h0000_0500;
  localparam logic [CSR_DW-1:0] RXCFG_KEEP = 32'h07FF_003F;
  localparam logic [CSR_DW-1:0] MSPD_KEEP  = 32'h0000_00FE;
  localparam logic [CSR_DW-1:0] TXWM_KEEP  = 32'h0000_0003;
  localparam logic [CSR_DW-1:0] BUF_KEEP   = 32'h0000_07F0;
  localparam logic [CSR_DW-1:0] FIFO_KEEP  = 32'h0000_03FC;
  localparam logic [CSR_DW-1:0] FIFO_FORCE = 32'h0000_0400;
  localparam logic [CSR_DW-1:0] PAUSE_VAL  = 32'h0001_0000;
  localparam logic [CSR_DW-1:0] FBOUND_VAL = 32'h0000_0600;
  localparam logic [15:0]       STA_TAIL   = 16'h8808;
  localparam int CTL_EN_BIT = 1;
  localparam int CTL_RST_BIT = 0;
  localparam int RXACT_BIT = 24;

  // interrupt line -> event index
  function automatic int irq_src(input int line);
    case (line)
      0: irq_src = E_TXF;
      1: irq_src = E_TXB;
      2: irq_src = E_UN;
      3: irq_src = E_RL;
      4: irq_src = E_RXF;
      5: irq_src = E_RXB;
      6: irq_src = E_MII;
      7: irq_src = E_LC;
      8: irq_src = E_HB;
      9: irq_src = E_GRA;
      10: irq_src = E_EB;
      11: irq_src = E_BABT;
      default: irq_src = E_BABR;
    endcase
  endfunction
endpackage

// File: rtl/fec_evt_unit.sv
module fec_evt_unit
  import fec_csr_pkg::*;
#(
  parameter int NE = N_EVT,
  parameter int DW = CSR_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          evt_wr,
  input  logic          msk_wr,
  input  logic [NE-1:0] clr_bits,
  input  logic [DW-1:0] msk_wdata,
  input  logic [NE-1:0] set_i,
  output logic [NE-1:0] evt_o,
  output logic [DW-1:0] msk_o,
  output logic [NE-1:0] irq_o
);
  localparam int LSB = DW - NE;

  logic [NE-1:0] evt_q, evt_kept;
  logic [DW-1:0] msk_q;
  logic [NE-1:0] irq_q;

  always_comb begin
    if (soft_clr)    evt_kept = '0;
    else if (evt_wr) evt_kept = evt_q & ~clr_bits;
    else             evt_kept = evt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      msk_q <= '0;
    end else begin
      evt_q <= evt_kept | set_i;
      if (soft_clr)    msk_q <= '0;
      else if (msk_wr) msk_q <= msk_wdata;
    end
  end

  for (genvar i = 0; i < NE; i++) begin : g_line
    localparam int SRC = irq_src(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[i] <= 1'b0;
      else        irq_q[i] <= evt_q[SRC] & msk_q[LSB+SRC];
    end
  end

  assign evt_o = evt_q;
  assign msk_o = msk_q;
  assign irq_o = irq_q;

  // R3
  evt_set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((evt_q & $past(set_i)) == $past(set_i)));
  // R4
  evt_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wr && !soft_clr) |=> ((evt_q & $past(clr_bits & ~set_i)) == '0));
  // R7
  evt_soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_clr && set_i == '0) |=> (evt_q == '0 && msk_q == '0));
endmodule

// File: rtl/fec_ctl_unit.sv
module fec_ctl_unit
  import fec_csr_pkg::*;
#(
  parameter int DW = CSR_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          rxact_wr,
  input  logic          txact_wr,
  input  logic          txcfg_wr,
  input  logic [DW-1:0] wdata,
  input  logic          rx_halt_i,
  output logic [DW-1:0] ctl_o,
  output logic [DW-1:0] txcfg_o,
  output logic          soft_rst_o,
  output logic          gra_set_o,
  output logic          rx_active_o,
  output logic          tx_kick_o
);
  logic [DW-1:0] ctl_q, txcfg_q;
  logic rxact_q, kick_q;

  assign soft_rst_o = ctl_wr & wdata[CTL_RST_BIT];
  assign gra_set_o  = txcfg_wr & wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      txcfg_q <= '0;
      rxact_q <= 1'b0;
      kick_q  <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= soft_rst_o ? '0 : wdata;
      if (soft_rst_o)    txcfg_q <= '0;
      else if (txcfg_wr) txcfg_q <= wdata;
      if (ctl_wr && (soft_rst_o || !wdata[CTL_EN_BIT])) rxact_q <= 1'b0;
      else if (rx_halt_i)                           rxact_q <= 1'b0;
      else if (rxact_wr && ctl_q[CTL_EN_BIT])       rxact_q <= 1'b1;
      kick_q <= txact_wr & ctl_q[CTL_EN_BIT];
    end
  end

  assign ctl_o       = ctl_q;
  assign txcfg_o     = txcfg_q;
  assign rx_active_o = rxact_q;
  assign tx_kick_o   = kick_q;

  // R8
  rx_off_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wdata[CTL_EN_BIT]) |=> !rx_active_o);
  // R8
  rx_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_halt_i && !ctl_wr) |=> !rx_active_o);
  // R9
  no_kick_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txact_wr && !ctl_q[CTL_EN_BIT]) |=> !tx_kick_o);
  // R9
  kick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_kick_o && !$past(txact_wr, 2)) |=> !tx_kick_o);
endmodule

// File: rtl/fec_cfg_regs.sv
module fec_cfg_regs
  import fec_csr_pkg::*;
#(
  parameter int AW = CSR_AW,
  parameter int DW = CSR_DW,
  parameter logic [47:0] STA_RST = 48'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          soft_rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mgmt_o,
  output logic [DW-1:0] mspd_o,
  output logic [DW-1:0] rxcfg_o,
  output logic [DW-1:0] txwm_o,
  output logic [DW-1:0] rxfifo_o,
  output logic [DW-1:0] rxring_o,
  output logic [DW-1:0] txring_o,
  output logic [DW-1:0] bufmax_o,
  output logic [47:0]   sta_o
);
  localparam logic [DW-1:0] RING_KEEP = ~{{(DW-2){1'b0}}, 2'b11};

  logic [DW-1:0] mgmt_q, mspd_q, rxcfg_q, txwm_q, rxfifo_q;
  logic [DW-1:0] rxring_q, txring_q, bufmax_q;
  logic [47:0]   sta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mgmt_q   <= '0;
      mspd_q   <= '0;
      rxcfg_q  <= RXCFG_RST;
      txwm_q   <= '0;
      rxfifo_q <= RXFIFO_RST;
      rxring_q <= '0;
      txring_q <= '0;
      bufmax_q <= '0;
      sta_q    <= STA_RST;
    end else if (soft_rst) begin
      mspd_q   <= '0;
      rxcfg_q  <= RXCFG_RST;
      txwm_q   <= '0;
      rxfifo_q <= RXFIFO_RST;
    end else if (wr) begin
      case (addr)
        OFF_MGMT:   mgmt_q   <= wdata;
        OFF_MSPD:   mspd_q   <= wdata & MSPD_KEEP;
        OFF_RXCFG:  rxcfg_q  <= wdata & RXCFG_KEEP;
        OFF_TXWM:   txwm_q   <= wdata & TXWM_KEEP;
        OFF_RXFIFO: rxfifo_q <= (wdata & FIFO_KEEP) | FIFO_FORCE;
        OFF_RXRING: rxring_q <= wdata & RING_KEEP;
        OFF_TXRING: txring_q <= wdata & RING_KEEP;
        OFF_BUFMAX: bufmax_q <= wdata & BUF_KEEP;
        OFF_STA_LO: sta_q[47:16] <= wdata;
        OFF_STA_HI: sta_q[15:0]  <= wdata[DW-1:DW-16];
        default: ;
      endcase
    end
  end

  assign mgmt_o   = mgmt_q;
  assign mspd_o   = mspd_q;
  assign rxcfg_o  = rxcfg_q;
  assign txwm_o   = txwm_q;
  assign rxfifo_o = rxfifo_q;
  assign rxring_o = rxring_q;
  assign txring_o = txring_q;
  assign bufmax_o = bufmax_q;
  assign sta_o    = sta_q;

  // R7
  soft_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rxcfg_q == RXCFG_RST && rxfifo_q == RXFIFO_RST && mspd_q == '0));
  // R7
  soft_keeps_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ($stable(rxring_q) && $stable(txring_q) && $stable(sta_q)));
endmodule

// File: rtl/fec_csr_top.sv
module fec_csr_top
  import fec_csr_pkg::*;
#(
  parameter logic [47:0] STA_RST = 48'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CSR_AW-1:0] req_addr,
  input  logic [CSR_DW-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [CSR_DW-1:0] rsp_rdata,
  input  logic [N_EVT-1:0]  evt_set_i,
  input  logic              rx_halt_i,
  output logic [N_EVT-1:0]  irq_o,
  output logic              mac_en_o,
  output logic              rx_active_o,
  output logic              tx_kick_o,
  output logic [CSR_DW-1:0] rx_cfg_o,
  output logic [CSR_DW-1:0] tx_cfg_o,
  output logic [47:0]       station_addr_o,
  output logic [CSR_DW-1:0] rx_ring_o,
  output logic [CSR_DW-1:0] tx_ring_o,
  output logic [CSR_DW-1:0] rx_buf_max_o
);
  logic wr, rd;
  logic soft_rst, gra_set;
  logic [N_EVT-1:0]  evt_vec, set_all;
  logic [CSR_DW-1:0] msk_vec, ctl_vec, mgmt_v, mspd_v, txwm_v, rxfifo_v;
  logic [CSR_DW-1:0] rd_mux;

  assign wr = req_valid & req_write;
  assign rd = req_valid & ~req_write;
  assign set_all = evt_set_i | (N_EVT'(gra_set) << E_GRA);

  fec_ctl_unit u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(wr && req_addr == OFF_CTL),
    .rxact_wr(wr && req_addr == OFF_RXACT),
    .txact_wr(wr && req_addr == OFF_TXACT),
    .txcfg_wr(wr && req_addr == OFF_TXCFG),
    .wdata(req_wdata), .rx_halt_i(rx_halt_i),
    .ctl_o(ctl_vec), .txcfg_o(tx_cfg_o),
    .soft_rst_o(soft_rst), .gra_set_o(gra_set),
    .rx_active_o(rx_active_o), .tx_kick_o(tx_kick_o)
  );

  fec_evt_unit u_evt (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
    .evt_wr(wr && req_addr == OFF_EVT),
    .msk_wr(wr && req_addr == OFF_MSK),
    .clr_bits(req_wdata[CSR_DW-1:EVT_LSB]),
    .msk_wdata(req_wdata), .set_i(set_all),
    .evt_o(evt_vec), .msk_o(msk_vec), .irq_o(irq_o)
  );

  fec_cfg_regs #(.STA_RST(STA_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(wr), .soft_rst(soft_rst),
    .addr(req_addr), .wdata(req_wdata),
    .mgmt_o(mgmt_v), .mspd_o(mspd_v), .rxcfg_o(rx_cfg_o), .txwm_o(txwm_v),
    .rxfifo_o(rxfifo_v), .rxring_o(rx_ring_o), .txring_o(tx_ring_o),
    .bufmax_o(rx_buf_max_o), .sta_o(station_addr_o)
  );

  assign mac_en_o = ctl_vec[CTL_EN_BIT];

  always_comb begin
    rd_mux = '0;
    case (req_addr)
      OFF_EVT:    rd_mux = {evt_vec, {EVT_LSB{1'b0}}};
      OFF_MSK:    rd_mux = msk_vec;
      OFF_RXACT:  rd_mux[RXACT_BIT] = rx_active_o;
      OFF_CTL:    rd_mux = ctl_vec;
      OFF_MGMT:   rd_mux = mgmt_v;
      OFF_MSPD:   rd_mux = mspd_v;
      OFF_RXCFG:  rd_mux = rx_cfg_o;
      OFF_TXCFG:  rd_mux = tx_cfg_o;
      OFF_STA_LO: rd_mux = station_addr_o[47:16];
      OFF_STA_HI: rd_mux = {station_addr_o[15:0], STA_TAIL};
      OFF_PAUSE:  rd_mux = PAUSE_VAL;
      OFF_TXWM:   rd_mux = txwm_v;
      OFF_FBOUND: rd_mux = FBOUND_VAL;
      OFF_RXFIFO: rd_mux = rxfifo_v;
      OFF_RXRING: rd_mux = rx_ring_o;
      OFF_TXRING: rd_mux = tx_ring_o;
      OFF_BUFMAX: rd_mux = rx_buf_max_o;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end

  // R2
  rsp_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  // R2
  rsp_only_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
  // R6
  gra_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == OFF_TXCFG && req_wdata[0]) |=> evt_vec[E_GRA]);
  // R5
  irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_vec == '0) |=> (irq_o == '0));
endmodule

// File: tb/fec_csr_top_tb_top.sv
module fec_csr_top_tb_top;
  localparam time CYC = 8ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [9:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [12:0] evt_set_i = '0;
  logic rx_halt_i = 1'b0;
  logic [12:0] irq_o;
  logic mac_en_o, rx_active_o, tx_kick_o;
  logic [31:0] rx_cfg_o, tx_cfg_o, rx_ring_o, tx_ring_o, rx_buf_max_o;
  logic [47:0] station_addr_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CYC/2) clk = ~clk;

  fec_csr_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .evt_set_i(evt_set_i), .rx_halt_i(rx_halt_i),
    .irq_o(irq_o), .mac_en_o(mac_en_o), .rx_active_o(rx_active_o),
    .tx_kick_o(tx_kick_o), .rx_cfg_o(rx_cfg_o), .tx_cfg_o(tx_cfg_o),
    .station_addr_o(station_addr_o), .rx_ring_o(rx_ring_o),
    .tx_ring_o(tx_ring_o), .rx_buf_max_o(rx_buf_max_o)
  );

  // line -> event bit position (R5 order)
  function automatic int line_bit(input int line);
    int tbl[13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
    return tbl[line];
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected response act=%h exp=none", rsp_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          n_fail++;
          $display("FAIL %s act=%h exp=%h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    req_valid = 1; req_write = 0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0;
    chk(rsp_valid, 1, "R2 rsp_valid after read");
  endtask

  task automatic pulse(input logic [12:0] v);
    @(posedge clk); #1; evt_set_i = v;
    @(posedge clk); #1; evt_set_i = '0;
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  initial begin
    #(CYC*100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick;
    // R1 reset state
    chk(irq_o, 0, "R1 irq after reset");
    rd(10'h004, 32'h0, "R1 event reset");
    rd(10'h008, 32'h0, "R1 mask reset");
    rd(10'h084, 32'h05EE0001, "R1 rx cfg reset");
    rd(10'h150, 32'h500, "R1 rx fifo reset");
    rd(10'h0E8, 32'h00008808, "R1 upper addr reset");
    tick;
    chk(rsp_valid, 0, "R2 rsp_valid idle");

    // R5 mask replace, R3/R5 per-line mapping
    wr(10'h008, 32'hFFFF_FFFF);
    rd(10'h008, 32'hFFFF_FFFF, "R5 mask readback");
    for (int l = 0; l < 13; l++) begin
      automatic int b = line_bit(l);
      pulse(13'(1) << (b - 19));
      tick;
      chk(irq_o, 13'(1) << l, $sformatf("R5 irq line %0d", l));
      rd(10'h004, 32'(1) << b, $sformatf("R3 event bit %0d", b));
      wr(10'h004, 32'(1) << b);
      tick;
      chk(irq_o, 0, $sformatf("R4 clear line %0d", l));
    end

    // R4 partial clear
    pulse(13'h1001);
    wr(10'h004, 32'h8000_0000);
    rd(10'h004, 32'h0008_0000, "R4 partial clear");
    // R4 collision: clear and set same cycle
    @(posedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = 10'h004; req_wdata = 32'h0008_0000;
    evt_set_i = 13'h0001;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0; evt_set_i = '0;
    rd(10'h004, 32'h0008_0000, "R4 set wins over clear");
    wr(10'h004, 32'hFFFF_FFFF);

    // R5 single-source mask
    wr(10'h008, 32'h0200_0000);
    pulse(13'h1FFF);
    tick;
    chk(irq_o, 13'h0010, "R5 only RXF line");
    wr(10'h008, 32'h0);
    tick;
    chk(irq_o, 0, "R5 mask removed");
    wr(10'h004, 32'hFFFF_FFFF);

    // R6 graceful stop event
    wr(10'h0C4, 32'h1);
    rd(10'h004, 32'h1000_0000, "R6 GRA raised");
    rd(10'h0C4, 32'h1, "R6 tx cfg readback");
    chk(tx_cfg_o, 32'h1, "R6 tx cfg port");
    wr(10'h004, 32'hFFFF_FFFF);

    // R8 receive activate ignored while disabled
    wr(10'h010, 32'h0);
    rd(10'h010, 32'h0, "R8 activate ignored when off");
    // R7 enable
    wr(10'h024, 32'h2);
    chk(mac_en_o, 1, "R7 enable port");
    wr(10'h010, 32'h0);
    chk(rx_active_o, 1, "R8 rx active port");
    rd(10'h010, 32'h0100_0000, "R8 rx active bit24");
    @(posedge clk); #1 rx_halt_i = 1;
    @(posedge clk); #1 rx_halt_i = 0;
    chk(rx_active_o, 0, "R8 halt clears");
    wr(10'h010, 32'h0);
    chk(rx_active_o, 1, "R8 rearm");
    wr(10'h024, 32'h0);
    chk(rx_active_o, 0, "R8 disable clears");
    chk(mac_en_o, 0, "R7 enable off");

    // R9 transmit kick
    wr(10'h014, 32'h0);
    chk(tx_kick_o, 0, "R9 no kick while off");
    wr(10'h024, 32'h2);
    wr(10'h014, 32'h0);
    chk(tx_kick_o, 1, "R9 kick pulse");
    tick;
    chk(tx_kick_o, 0, "R9 kick single cycle");
    rd(10'h014, 32'h0, "R9 reads zero");

    // R10 write masks
    wr(10'h044, 32'hFFFF_FFFF); rd(10'h044, 32'hFE, "R10 mii speed");
    wr(10'h084, 32'hFFFF_FFFF); rd(10'h084, 32'h07FF003F, "R10 rx cfg");
    chk(rx_cfg_o, 32'h07FF003F, "R10 rx cfg port");
    wr(10'h144, 32'hFFFF_FFFF); rd(10'h144, 32'h3, "R10 watermark");
    wr(10'h188, 32'hFFFF_FFFF); rd(10'h188, 32'h7F0, "R10 buffer max");
    wr(10'h150, 32'h0000_0003); rd(10'h150, 32'h400, "R10 fifo start low");
    wr(10'h150, 32'hFFFF_FFFF); rd(10'h150, 32'h7FC, "R10 fifo start");
    wr(10'h180, 32'h1234_5677); rd(10'h180, 32'h1234_5674, "R10 rx ring");
    wr(10'h184, 32'hFFFF_FFFF); rd(10'h184, 32'hFFFF_FFFC, "R10 tx ring");
    chk(rx_ring_o, 32'h1234_5674, "R10 rx ring port");
    chk(tx_ring_o, 32'hFFFF_FFFC, "R10 tx ring port");

    // R11 station address
    wr(10'h0E4, 32'hA1B2_C3D4);
    wr(10'h0E8, 32'hE5F6_1234);
    rd(10'h0E4, 32'hA1B2_C3D4, "R11 lower addr");
    rd(10'h0E8, 32'hE5F6_8808, "R11 upper addr");
    chk(station_addr_o, 48'hA1B2_C3D4_E5F6, "R11 addr port");

    // R12 constant locations
    rd(10'h0EC, 32'h0001_0000, "R12 pause value");
    wr(10'h14C, 32'hFFFF_FFFF);
    rd(10'h14C, 32'h600, "R12 fifo bound ignores write");
    rd(10'h118, 32'h0, "R12 hash reads zero");
    rd(10'h064, 32'h0, "R12 stats reads zero");

    // R7 soft reset
    wr(10'h008, 32'hFFFF_FFFF);
    wr(10'h0C4, 32'h2);
    pulse(13'h0001);
    wr(10'h024, 32'h3);
    rd(10'h004, 32'h0, "R7 event cleared");
    rd(10'h008, 32'h0, "R7 mask cleared");
    rd(10'h024, 32'h0, "R7 control cleared");
    rd(10'h084, 32'h05EE0001, "R7 rx cfg default");
    rd(10'h150, 32'h500, "R7 fifo default");
    rd(10'h044, 32'h0, "R7 mii speed cleared");
    rd(10'h144, 32'h0, "R7 watermark cleared");
    rd(10'h0C4, 32'h0, "R7 tx cfg cleared");
    rd(10'h184, 32'hFFFF_FFFC, "R7 ring kept");
    rd(10'h188, 32'h7F0, "R7 buffer max kept");
    chk(mac_en_o, 0, "R7 enable after soft reset");
    chk(irq_o, 0, "R7 irq after soft reset");

    repeat (3) tick;
    chk(exp_q.size(), 0, "R2 all reads answered");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule